// File: doc/BRIEF.md
# Packed Init-Script Interpreter

This block runs a display controller's power-up script that is held in a small byte-wide ROM. After a start strobe it reads the table one byte at a time and splits it into records. The first byte of each record is a header. Its top bit asks for a wait, the bit below asks for a command byte, and the low six bits give a count of data bytes. The payload bytes that follow the header go out on a byte-wide write stream, each tagged as command or data, and any wait is timed against an external tick.

Within a record the payload order is fixed: the command byte (if any), then the data bytes, then the wait byte (if any). The select output is held active for the whole run. When the read pointer reaches the programmed length, the block stops, even if a record is only partly read, and raises done.

The write stream uses valid/ready. A byte counts as written on the cycle where `wr_valid_o` and `wr_ready_i` are both high. While valid is high and ready is low, the byte and its tag hold still and the interpreter waits. Ready may stay low for any number of cycles. Nothing else in the block depends on it.

Top module: `init_seq_interp`

## Requirements
- R1: When header bit 6 is set, the next table byte is emitted as one write with `wr_dc_o` low (command), and it comes before any data byte of that record.
- R2: Header bits 5:0 (value 0 to 63) give how many following table bytes are emitted as writes with `wr_dc_o` high (data). They come after the command byte and in table order.
- R3: When header bit 7 is set, the byte after the data bytes is a wait count N. No further write happens until at least N tick pulses have been seen, and the run resumes within a few ticks of the N-th.
- R4: A wait count of 0 adds no wait, and a header with no flags and a count of 0 produces no write.
- R5: The run ends when the read address equals `tbl_len_i`, even in the middle of a record. `done_o` then stays high until the next start, and a start clears it on the next cycle.
- R6: `sel_o` is high from the cycle after start until the run ends, covers every write, and is low while idle or done.
- R7: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_byte_o` and `wr_dc_o` hold their values into the next cycle.
- R8: After reset, `sel_o`, `wr_valid_o`, `done_o` and `rom_en_o` are low.
- R9: The ROM is read once per table byte, in rising address order, only at addresses below `tbl_len_i`, with one cycle of read latency. A run of length L makes exactly L reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe; starts a run when idle or done |
| tbl_len_i | input | AW | Number of table bytes; held stable during a run |
| rom_en_o | output | 1 | ROM read enable |
| rom_addr_o | output | AW | ROM read address |
| rom_data_i | input | 8 | ROM byte, valid the cycle after `rom_en_o` |
| wr_valid_o | output | 1 | Write byte available |
| wr_ready_i | input | 1 | Bus accepts the write |
| wr_dc_o | output | 1 | 0 = command byte, 1 = data byte |
| wr_byte_o | output | 8 | Byte to write |
| sel_o | output | 1 | Controller select, active high |
| tick_i | input | 1 | One-cycle timing tick |
| done_o | output | 1 | Run finished |

## Verification
A decoder that loses track of which byte role comes next shows up at once in the write stream. A byte comes out with the wrong command/data tag, a wait byte leaks out as data, or a header is swallowed, and the first write of the damaged record already differs. A wrong read pointer or a wrong end comparison shows up as a write count that differs from the prefix model, or as a read at or past the length, and this is visible for every truncation length in the sweep. A wait counter that is off shows up as a gap in the tick stamps between the surrounding writes that is too short, or too long when ready is held high. The lower bound catches this on the first write after the wait.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = 6;
  localparam int CMD_BIT   = 6;
  localparam int WAIT_BIT  = 7;

  typedef enum logic [1:0] {
    ROLE_HDR,
    ROLE_CMD,
    ROLE_DATA,
    ROLE_WAIT
  } role_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TAKE,
    ST_SEND,
    ST_WAIT,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic             has_wait;
    logic             has_cmd;
    logic [CNT_W-1:0] count;
  } hdr_t;

  function automatic hdr_t hdr_unpack(input logic [BYTE_W-1:0] b);
    hdr_t h;
    h.has_wait = b[WAIT_BIT];
    h.has_cmd  = b[CMD_BIT];
    h.count    = b[CNT_W-1:0];
    return h;
  endfunction

  // Role of the next table byte given what is still owed by the record.
  function automatic role_e role_next(input logic cmd_owed,
                                      input logic [CNT_W-1:0] data_owed,
                                      input logic wait_owed);
    if (cmd_owed)             return ROLE_CMD;
    else if (data_owed != '0) return ROLE_DATA;
    else if (wait_owed)       return ROLE_WAIT;
    else                      return ROLE_HDR;
  endfunction
endpackage

// File: rtl/init_seq_fetch.sv
module init_seq_fetch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic          at_end_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (step_i)  ptr_q <= ptr_q + 1'b1;
  end

  assign addr_o   = ptr_q;
  assign at_end_o = (ptr_q >= len_i);
endmodule

// File: rtl/init_seq_timer.sv
module init_seq_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] value_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [DW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        left_q <= '0;
    else if (load_i)                   left_q <= value_i;
    else if (tick_i && left_q != '0)   left_q <= left_q - 1'b1;
  end

  // Fires on the tick that takes the count from one to zero.
  assign expire_o = tick_i && (left_q == DW'(1));
endmodule

// File: rtl/init_seq_interp.sv
module init_seq_interp
  import init_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     tbl_len_i,
  output logic              rom_en_o,
  output logic [AW-1:0]     rom_addr_o,
  input  logic [BYTE_W-1:0] rom_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic              wr_dc_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              sel_o,
  input  logic              tick_i,
  output logic              done_o
);
  state_e            state_q;
  role_e             role_q;
  logic              cmd_owed_q, wait_owed_q;
  logic [CNT_W-1:0]  data_owed_q;
  logic [BYTE_W-1:0] byte_q;
  logic              dc_q;

  logic at_end, launch, step, t_load, t_expire;
  hdr_t hdr;

  assign launch = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign step   = (state_q == ST_READ) && !at_end;
  assign hdr    = hdr_unpack(rom_data_i);
  assign t_load = (state_q == ST_TAKE) && (role_q == ROLE_WAIT) &&
                  (rom_data_i != '0);

  init_seq_fetch #(.AW(AW)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (launch),
    .step_i   (step),
    .len_i    (tbl_len_i),
    .addr_o   (rom_addr_o),
    .at_end_o (at_end)
  );

  init_seq_timer #(.DW(BYTE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (t_load),
    .value_i  (rom_data_i),
    .tick_i   (tick_i),
    .expire_o (t_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      role_q      <= ROLE_HDR;
      cmd_owed_q  <= 1'b0;
      wait_owed_q <= 1'b0;
      data_owed_q <= '0;
      byte_q      <= '0;
      dc_q        <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (launch) begin
            state_q     <= ST_READ;
            role_q      <= ROLE_HDR;
            cmd_owed_q  <= 1'b0;
            wait_owed_q <= 1'b0;
            data_owed_q <= '0;
          end
        end
        ST_READ: begin
          state_q <= at_end ? ST_DONE : ST_TAKE;
        end
        ST_TAKE: begin
          case (role_q)
            ROLE_HDR: begin
              cmd_owed_q  <= hdr.has_cmd;
              data_owed_q <= hdr.count;
              wait_owed_q <= hdr.has_wait;
              role_q      <= role_next(hdr.has_cmd, hdr.count, hdr.has_wait);
              state_q     <= ST_READ;
            end
            ROLE_CMD: begin
              byte_q     <= rom_data_i;
              dc_q       <= 1'b0;
              cmd_owed_q <= 1'b0;
              role_q     <= role_next(1'b0, data_owed_q, wait_owed_q);
              state_q    <= ST_SEND;
            end
            ROLE_DATA: begin
              byte_q      <= rom_data_i;
              dc_q        <= 1'b1;
              data_owed_q <= data_owed_q - 1'b1;
              role_q      <= role_next(1'b0, data_owed_q - 1'b1, wait_owed_q);
              state_q     <= ST_SEND;
            end
            default: begin
              wait_owed_q <= 1'b0;
              role_q      <= ROLE_HDR;
              state_q     <= (rom_data_i == '0) ? ST_READ : ST_WAIT;
            end
          endcase
        end
        ST_SEND: begin
          if (wr_ready_i) state_q <= ST_READ;
        end
        ST_WAIT: begin
          if (t_expire) state_q <= ST_READ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rom_en_o   = step;
  assign wr_valid_o = (state_q == ST_SEND);
  assign wr_byte_o  = byte_q;
  assign wr_dc_o    = dc_q;
  assign sel_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/init_seq_interp_chk.sv
module init_seq_interp_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [AW-1:0] tbl_len_i,
  input logic          rom_en_o,
  input logic [AW-1:0] rom_addr_o,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic          wr_dc_o,
  input logic [7:0]    wr_byte_o,
  input logic          sel_o,
  input logic          done_o
);
  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_byte_o) && $stable(wr_dc_o)); // R7

  AST_SEL_COVERS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> sel_o); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sel_o && !wr_valid_o && !rom_en_o); // R5

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && start_i |=> !done_o && sel_o); // R5

  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en_o |-> rom_addr_o < tbl_len_i); // R9

  AST_READ_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en_o |=> !wr_valid_o && !rom_en_o); // R9
endmodule

bind init_seq_interp init_seq_interp_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .tbl_len_i  (tbl_len_i),
  .rom_en_o   (rom_en_o),
  .rom_addr_o (rom_addr_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_dc_o    (wr_dc_o),
  .wr_byte_o  (wr_byte_o),
  .sel_o      (sel_o),
  .done_o     (done_o)
);

// File: tb/init_seq_interp_tb.sv
module init_seq_interp_tb;
  localparam int AW = 8;
  localparam int TBL_N = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] tbl_len_i = '0;
  logic          rom_en_o;
  logic [AW-1:0] rom_addr_o;
  logic [7:0]    rom_data_i = '0;
  logic          wr_valid_o, wr_ready_i, wr_dc_o, sel_o, done_o;
  logic [7:0]    wr_byte_o;
  logic          tick_i = 1'b0;

  int checks = 0, fails = 0;
  logic [7:0] rom [TBL_N];

  // Captured writes
  int got_n, reads_n, bad_reads, sel_miss, ticks;
  logic       got_dc [64];
  logic [7:0] got_b  [64];
  int         got_t  [64];
  // Expected writes
  int exp_n;
  logic       exp_dc [64];
  logic [7:0] exp_b  [64];
  int         exp_d  [64];

  logic rdy_always = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  int tphase = 0;

  always #4 clk = ~clk;

  init_seq_interp #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tbl_len_i(tbl_len_i),
    .rom_en_o(rom_en_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_dc_o(wr_dc_o),
    .wr_byte_o(wr_byte_o), .sel_o(sel_o), .tick_i(tick_i), .done_o(done_o)
  );

  // ROM model with one cycle of read latency
  always_ff @(posedge clk) if (rom_en_o) rom_data_i <= rom[rom_addr_o];

  assign wr_ready_i = rdy_always | lfsr[0];

  // Input drivers: ready pattern and tick every fourth cycle
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tphase = (tphase + 1) % 4;
      tick_i = (tphase == 0);
    end
  end

  // Monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick_i) ticks++;
      if (rom_en_o) begin
        reads_n++;
        if (rom_addr_o >= tbl_len_i) bad_reads++;
      end
      if (wr_valid_o && wr_ready_i) begin
        if (!sel_o) sel_miss++;
        if (got_n < 64) begin
          got_dc[got_n] = wr_dc_o;
          got_b[got_n]  = wr_byte_o;
          got_t[got_n]  = ticks;
        end
        got_n++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Bench model of the record format, consuming only the first len bytes
  task automatic build_exp(input int len);
    int idx = 0, pend = 0;
    bit stop = 0;
    exp_n = 0;
    while (idx < len && !stop) begin
      logic [7:0] h = rom[idx];
      idx++;
      if (h[6]) begin
        if (idx >= len) stop = 1;
        else begin
          exp_dc[exp_n] = 0; exp_b[exp_n] = rom[idx]; exp_d[exp_n] = pend;
          pend = 0; exp_n++; idx++;
        end
      end
      for (int c = 0; c < int'(h[5:0]) && !stop; c++) begin
        if (idx >= len) stop = 1;
        else begin
          exp_dc[exp_n] = 1; exp_b[exp_n] = rom[idx]; exp_d[exp_n] = pend;
          pend = 0; exp_n++; idx++;
        end
      end
      if (h[7] && !stop) begin
        if (idx >= len) stop = 1;
        else begin pend += int'(rom[idx]); idx++; end
      end
    end
  endtask

  task automatic run_case(input int len, input bit upper);
    int guard = 0;
    build_exp(len);
    @(posedge clk); #1;
    tbl_len_i = AW'(len);
    got_n = 0; reads_n = 0; bad_reads = 0; sel_miss = 0; ticks = 0;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    check(sel_o == 1'b1 && done_o == 1'b0, "R6", "sel after start", sel_o, 1);
    while (!done_o && guard < 5000) begin @(negedge clk); guard++; end
    check(done_o == 1'b1, "R5", "run finished", done_o, 1);
    check(got_n == exp_n, "R5", "write count", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n && k < 64; k++) begin
      check(got_dc[k] == exp_dc[k], exp_dc[k] ? "R2" : "R1", "write tag",
            got_dc[k], exp_dc[k]);
      check(got_b[k] == exp_b[k], exp_dc[k] ? "R2" : "R1", "write byte",
            got_b[k], exp_b[k]);
      if (k > 0 && exp_d[k] > 0) begin
        check(got_t[k] - got_t[k-1] >= exp_d[k], "R3", "wait lower bound",
              got_t[k] - got_t[k-1], exp_d[k]);
        if (upper)
          check(got_t[k] - got_t[k-1] <= exp_d[k] + 4, "R3", "wait upper bound",
                got_t[k] - got_t[k-1], exp_d[k] + 4);
      end
      if (k > 0 && exp_d[k] == 0 && upper)
        check(got_t[k] - got_t[k-1] <= 3, "R4", "no wait added",
              got_t[k] - got_t[k-1], 3);
    end
    check(reads_n == len, "R9", "read count", reads_n, len);
    check(bad_reads == 0, "R9", "reads past length", bad_reads, 0);
    check(sel_miss == 0, "R6", "writes without select", sel_miss, 0);
    repeat (3) @(negedge clk);
    check(done_o == 1'b1 && sel_o == 1'b0, "R5", "done held, select low",
          {done_o, sel_o}, 2);
  endtask

  initial begin
    // Test table: cmd+3 data; cmd+1 data+wait 3; zero wait; 2 data;
    // cmd only; 1 data+wait 2; empty header; cmd+1 data
    rom[0]=8'h43; rom[1]=8'hB1; rom[2]=8'h11; rom[3]=8'h22; rom[4]=8'h33;
    rom[5]=8'hC1; rom[6]=8'h2C; rom[7]=8'h55; rom[8]=8'h03;
    rom[9]=8'h80; rom[10]=8'h00;
    rom[11]=8'h02; rom[12]=8'hA0; rom[13]=8'hA1;
    rom[14]=8'h40; rom[15]=8'h29;
    rom[16]=8'h81; rom[17]=8'h77; rom[18]=8'h02;
    rom[19]=8'h00;
    rom[20]=8'h41; rom[21]=8'h36; rom[22]=8'h00;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sel_o == 0 && wr_valid_o == 0 && done_o == 0 && rom_en_o == 0,
          "R8", "reset outputs", {sel_o, wr_valid_o, done_o, rom_en_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel_o == 0 && done_o == 0, "R8", "idle after reset", {sel_o, done_o}, 0);

    // Sweep every truncation length under random back-pressure (R5, R7)
    for (int len = 0; len <= TBL_N; len++) run_case(len, 1'b0);
    // Full table and a mid-wait truncation with ready held high (R3, R4)
    rdy_always = 1'b1;
    run_case(TBL_N, 1'b1);
    run_case(19, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule